// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block takes an external DRAM from power-on to normal operation with no software stepping through the commands. A single start pulse sets it going. It enables the PHY delay-locked loop and waits for the lock flag. It keeps every clock-enable low until a stable-clock interval, measured from reset release, has run out. It then works through each populated chip-select in order. For each one it raises that chip's clock-enable with a NOP and programs the mode registers. It waits a settle interval, then reads the auto-initialization status through mode-register reads until the device reports that it has finished. After the last chip it turns on the auto-refresh counter and signals completion.

All intervals are counted in clock cycles. They are derived from a cycles-per-microsecond parameter, so a test build can use very short delays. Commands leave the block as a one-cycle strobe carrying a command code and a chip index. The memory-side logic that issues the command answers each mode-register read with a data-valid pulse. A device that never completes makes the poll give up after a set number of reads. The sequencer then stops with an error flag.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted and after its release until a start pulse, every clock-enable, the DLL enable, the command strobe, the refresh enable, the done flag and the error flag are all low.
- R2: A start pulse accepted while idle, done or failed raises the DLL enable in the next cycle, and the DLL enable stays high. No command is issued until the DLL-locked input has been seen high, and the first NOP follows the cycle in which lock is sampled by two cycles.
- R3: The clock-enable of chip i rises in the same cycle as a NOP strobe addressed to chip i and never falls afterwards. The first NOP comes no earlier than STABLE_US*CYC_PER_US+1 cycles after reset release.
- R4: Command codes are NOP=1, MRS=2, MRR=3. An MRS to the same chip follows every NOP in the next cycle. The first MRR after an MRS comes exactly SETTLE_US*CYC_PER_US+1 cycles after it.
- R5: A read response (read-valid high) with data bit DAI_BIT clear makes the block issue another MRR to the same chip in the following cycle. With that bit set, the block moves to the next chip or finishes. Other data bits are ignored.
- R6: When MAX_POLL reads of one chip all report "not finished", the error flag rises in the cycle after the last response. After that no further commands are issued, refresh stays off and the flag holds until the next start.
- R7: The chip count is sampled at start. A count of 0 means one chip, and a count above NUM_CS means NUM_CS chips. The NOP, MRS, settle and poll steps run for chip 0, then for each further chip in index order. The NOP to the next chip follows the completing response by one cycle.
- R8: The refresh enable and the done flag are low during initialization. Both rise together in the cycle after the completing response of the last chip, and both stay high until the next start.
- R9: A start pulse while initialization is in progress has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| chip_cnt_i | input | CNT_W | Number of populated chips |
| dll_lock_i | input | 1 | PHY DLL locked |
| mr_rvalid_i | input | 1 | Mode-register read response valid |
| mr_rdata_i | input | MR_W | Mode-register read data |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 2 | Command code (NOP=1, MRS=2, MRR=3) |
| cmd_cs_o | output | CS_W | Target chip index |
| cke_o | output | NUM_CS | Per-chip clock-enable |
| dll_en_o | output | 1 | PHY DLL enable |
| aref_en_o | output | 1 | Auto-refresh counter enable |
| done_o | output | 1 | Initialization complete |
| err_o | output | 1 | Poll retry limit exceeded |

## Verification
The bench builds the block with CYC_PER_US=2, STABLE_US=4, SETTLE_US=2 and MAX_POLL=3. That gives an 8-cycle stable-clock wait, a 4-cycle settle and at most three reads per chip. With these values a full run takes a few dozen cycles. The sweep can therefore cover every chip count from 0 to 3. For two chips it covers every pairing of 0 to 3 "not finished" replies, and that includes the retry limit on either chip. Every command time is compared against an arithmetic schedule. Extra runs hold the lock flag low at restart and pulse start in the middle of a run.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_NOP  = 2'd1,
    CMD_MRS  = 2'd2,
    CMD_MRR  = 2'd3
  } dinit_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DLL,
    ST_STAB,
    ST_NOP,
    ST_MRS,
    ST_SETTLE,
    ST_MRR,
    ST_RDWAIT,
    ST_DONE,
    ST_ERR
  } dinit_st_e;

  // cycle count of an interval given in microseconds
  function automatic int unsigned us_to_cyc(input int unsigned cyc_per_us,
                                            input int unsigned us);
    return cyc_per_us * us;
  endfunction

  // counter width able to hold values 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/dinit_pwr_timer.sv
// Saturating count of cycles since reset release; flags the stable-clock point.
module dinit_pwr_timer #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic stable_o
);
  localparam int unsigned W = dinit_pkg::cnt_width(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/dinit_delay.sv
// Countdown armed by load_i; expired_o is high once CYC cycles have elapsed.
module dinit_delay #(
  parameter int unsigned CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned W = dinit_pkg::cnt_width(CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= W'(CYC - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dinit_poll_ctr.sv
// Counts unfinished status reads of the current chip.
module dinit_poll_ctr #(
  parameter int unsigned MAX = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = dinit_pkg::cnt_width(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == W'(MAX - 1));
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dinit_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned STABLE_US  = 200,
  parameter int unsigned SETTLE_US  = 1,
  parameter int unsigned MAX_POLL   = 64,
  parameter int unsigned NUM_CS     = 2,
  parameter int unsigned MR_W       = 8,
  parameter int unsigned DAI_BIT    = 0,
  localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_CS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  chip_cnt_i,
  input  logic              dll_lock_i,
  input  logic              mr_rvalid_i,
  input  logic [MR_W-1:0]   mr_rdata_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_code_o,
  output logic [CS_W-1:0]   cmd_cs_o,
  output logic [NUM_CS-1:0] cke_o,
  output logic              dll_en_o,
  output logic              aref_en_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned STABLE_CYC = us_to_cyc(CYC_PER_US, STABLE_US);
  localparam int unsigned SETTLE_CYC = us_to_cyc(CYC_PER_US, SETTLE_US);

  // index of the last chip to initialize for a given requested count
  function automatic logic [CS_W-1:0] last_cs_of(input logic [CNT_W-1:0] cnt);
    if (cnt == '0)                 return '0;
    else if (int'(cnt) >= NUM_CS)  return CS_W'(NUM_CS - 1);
    else                           return CS_W'(int'(cnt) - 1);
  endfunction

  dinit_st_e        st_q, st_nx;
  logic [CS_W-1:0]  cs_q, last_cs_q;
  logic             dll_en_q;
  logic             pwr_stable, settle_done, poll_last, last_cs;

  // named internal events
  logic ev_start_acc, ev_poll_hit, ev_poll_miss, ev_chip_next, ev_fail;

  assign last_cs      = (cs_q == last_cs_q);
  assign ev_start_acc = start_i && (st_q == ST_IDLE || st_q == ST_DONE || st_q == ST_ERR);
  assign ev_poll_hit  = (st_q == ST_RDWAIT) && mr_rvalid_i &&  mr_rdata_i[DAI_BIT];
  assign ev_poll_miss = (st_q == ST_RDWAIT) && mr_rvalid_i && !mr_rdata_i[DAI_BIT];
  assign ev_chip_next = ev_poll_hit && !last_cs;
  assign ev_fail      = ev_poll_miss && poll_last;

  dinit_pwr_timer #(.LIMIT(STABLE_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .stable_o(pwr_stable)
  );

  dinit_delay #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(st_q == ST_MRS), .expired_o(settle_done)
  );

  dinit_poll_ctr #(.MAX(MAX_POLL)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr_i(st_q == ST_MRS),
    .inc_i(ev_poll_miss && !poll_last), .last_o(poll_last)
  );

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_IDLE, ST_DONE, ST_ERR: if (start_i) st_nx = ST_DLL;
      ST_DLL:    if (dll_lock_i)  st_nx = ST_STAB;
      ST_STAB:   if (pwr_stable)  st_nx = ST_NOP;
      ST_NOP:    st_nx = ST_MRS;
      ST_MRS:    st_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) st_nx = ST_MRR;
      ST_MRR:    st_nx = ST_RDWAIT;
      ST_RDWAIT: begin
        if (ev_poll_hit)       st_nx = last_cs ? ST_DONE : ST_NOP;
        else if (ev_poll_miss) st_nx = poll_last ? ST_ERR : ST_MRR;
      end
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cs_q      <= '0;
      last_cs_q <= '0;
      dll_en_q  <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (ev_start_acc) begin
        cs_q      <= '0;
        last_cs_q <= last_cs_of(chip_cnt_i);
        dll_en_q  <= 1'b1;
      end else if (ev_chip_next) begin
        cs_q <= cs_q + 1'b1;
      end
    end
  end

  // per-chip clock-enable: rises with the NOP to that chip, then held
  logic [NUM_CS-1:0] cke_q;
  logic [NUM_CS-1:0] nop_hit;

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cke
    assign nop_hit[gi] = (st_q == ST_NOP) && (cs_q == CS_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cke_q[gi] <= 1'b0;
      else if (nop_hit[gi]) cke_q[gi] <= 1'b1;
    end
  end

  dinit_cmd_e cmd_e;
  always_comb begin
    case (st_q)
      ST_NOP:  cmd_e = CMD_NOP;
      ST_MRS:  cmd_e = CMD_MRS;
      ST_MRR:  cmd_e = CMD_MRR;
      default: cmd_e = CMD_NONE;
    endcase
  end

  assign cmd_valid_o = (cmd_e != CMD_NONE);
  assign cmd_code_o  = cmd_e;
  assign cmd_cs_o    = cs_q;
  assign cke_o       = cke_q | nop_hit;
  assign dll_en_o    = dll_en_q;
  assign aref_en_o   = (st_q == ST_DONE);
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = (st_q == ST_ERR);

endmodule

// File: rtl/dinit_chk.sv
module dinit_chk
  import dinit_pkg::*;
#(
  parameter int unsigned NUM_CS     = 2,
  parameter int unsigned CS_W       = 1,
  parameter int unsigned MR_W       = 8,
  parameter int unsigned DAI_BIT    = 0,
  parameter int unsigned STABLE_CYC = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              dll_en_o,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_code_o,
  input logic [CS_W-1:0]   cmd_cs_o,
  input logic [NUM_CS-1:0] cke_o,
  input logic              mr_rvalid_i,
  input logic [MR_W-1:0]   mr_rdata_i,
  input logic              aref_en_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int unsigned PW = cnt_width(STABLE_CYC + 1);
  localparam int unsigned GW = cnt_width(SETTLE_CYC + 2);

  logic [PW-1:0] pwr_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_cnt <= '0;
    else if (pwr_cnt != PW'(STABLE_CYC + 1)) pwr_cnt <= pwr_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_cnt <= '0;
    else if (cmd_valid_o && cmd_code_o == CMD_MRS) gap_cnt <= GW'(1);
    else if (gap_cnt != '0 && gap_cnt != GW'(SETTLE_CYC + 2)) gap_cnt <= gap_cnt + 1'b1;
  end

  // R2
  dll_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> $past(start_i));
  // R2
  dll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dll_en_o) |-> dll_en_o);
  // R3
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o & $past(cke_o)) == $past(cke_o));
  // R3
  cke_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cke_o & ~$past(cke_o)) != '0) |-> (cmd_valid_o && cmd_code_o == CMD_NOP));
  // R3
  cke_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (pwr_cnt >= PW'(STABLE_CYC)));
  // R4
  nop_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_code_o == CMD_NOP) |=>
      (cmd_valid_o && cmd_code_o == CMD_MRS && $stable(cmd_cs_o)));
  // R4
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_code_o == CMD_MRR) |-> (gap_cnt >= GW'(SETTLE_CYC + 1)));
  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!cmd_valid_o && !aref_en_o && !done_o));
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);
  // R7
  cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (int'(cmd_cs_o) < NUM_CS));
  // R8
  aref_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aref_en_o == done_o);
  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mr_rvalid_i && mr_rdata_i[DAI_BIT]));
endmodule

bind dram_init_seq dinit_chk #(
  .NUM_CS(NUM_CS), .CS_W(CS_W), .MR_W(MR_W), .DAI_BIT(DAI_BIT),
  .STABLE_CYC(STABLE_CYC), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dll_en_o(dll_en_o),
  .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o), .cmd_cs_o(cmd_cs_o),
  .cke_o(cke_o), .mr_rvalid_i(mr_rvalid_i), .mr_rdata_i(mr_rdata_i),
  .aref_en_o(aref_en_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;
  localparam int CPU = 2, STB = 4, STL = 2, MAXP = 3, NCS = 2;
  localparam int SC  = CPU * STB;   // stable-clock cycles
  localparam int SET = CPU * STL;   // settle cycles
  localparam int LAT = 2;           // responder latency (negedges)

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, start = 1'b0, dll_lock = 1'b0;
  logic [1:0] chip_cnt = 2'd1;
  logic       rd_vld = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       cmd_valid, dll_en, aref_en, done, err;
  logic [1:0] cmd_code, cke;
  logic [0:0] cmd_cs;

  dram_init_seq #(.CYC_PER_US(CPU), .STABLE_US(STB), .SETTLE_US(STL),
                  .MAX_POLL(MAXP), .NUM_CS(NCS), .MR_W(8), .DAI_BIT(0)) u_dram_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chip_cnt_i(chip_cnt),
    .dll_lock_i(dll_lock), .mr_rvalid_i(rd_vld), .mr_rdata_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_cs_o(cmd_cs),
    .cke_o(cke), .dll_en_o(dll_en), .aref_en_o(aref_en), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle index = posedges since reset release
  int pc = 0;
  always @(posedge clk) if (!rst_n) pc <= 0; else pc <= pc + 1;

  // command log and monitors
  int         log_t [0:63];
  logic [1:0] log_c [0:63];
  int         log_s [0:63];
  int         log_n = 0, t_end = -1, v_dll = 0, v_cke = 0, v_aref = 0;
  logic [1:0] exp_cke = 2'b00;
  logic       prev_fin = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      if (log_n < 64) begin
        log_t[log_n] = pc; log_c[log_n] = cmd_code; log_s[log_n] = int'(cmd_cs);
      end
      log_n++;
      if (!dll_lock) v_dll++;
      if (cmd_code == 2'd1) exp_cke[cmd_cs] = 1'b1;
    end
    if (cke != exp_cke) v_cke++;
    if (aref_en != done) v_aref++;
    if ((done || err) && !prev_fin) t_end = pc;
    prev_fin = done || err;
  end

  // device model: answers each MRR after LAT cycles; first kk[c] answers unfinished
  int kk [0:1];
  int seen [0:1];
  initial begin
    int wcnt = 0, wcs = 0;
    kk[0] = 0; kk[1] = 0; seen[0] = 0; seen[1] = 0;
    forever begin
      @(negedge clk);
      rd_vld = 1'b0;
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          rd_vld  = 1'b1;
          rd_data = (seen[wcs] >= kk[wcs]) ? 8'h01 : 8'hFE;
          seen[wcs]++;
        end
      end
      if (rst_n && cmd_valid && cmd_code == 2'd3) begin
        wcnt = LAT; wcs = int'(cmd_cs);
      end
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_case(input int cc, input int k0, input int k1,
                          input bit lock_low, input bit poke, input bit first);
    int nchip, e_n, s, lt, bad_t, bad_i, exp_t, np;
    bit err_exp, seq_ok;
    logic [1:0] e_c [0:63];
    int e_s [0:63];
    int ks [0:1];
    nchip = (cc == 0) ? 1 : ((cc > NCS) ? NCS : cc);
    ks[0] = k0; ks[1] = k1;
    e_n = 0; err_exp = 0;
    for (int c = 0; c < nchip && !err_exp; c++) begin
      e_c[e_n] = 2'd1; e_s[e_n] = c; e_n++;
      e_c[e_n] = 2'd2; e_s[e_n] = c; e_n++;
      np = (ks[c] + 1 < MAXP) ? ks[c] + 1 : MAXP;
      for (int p = 0; p < np; p++) begin e_c[e_n] = 2'd3; e_s[e_n] = c; e_n++; end
      if (ks[c] >= MAXP) err_exp = 1;
    end

    log_n = 0; t_end = -1; v_dll = 0; v_cke = 0; v_aref = 0;
    kk[0] = k0; kk[1] = k1; seen[0] = 0; seen[1] = 0;
    lt = 0;
    @(negedge clk);
    chip_cnt = 2'(cc);
    if (lock_low) dll_lock = 1'b0;
    start = 1'b1; s = pc;
    @(negedge clk);
    start = 1'b0;
    if (first) chk(dll_en == 1'b1, "R2", "dll_en after start", dll_en, 1);
    if (lock_low) begin
      repeat (4) @(negedge clk);
      chk(log_n == 0, "R2", "commands before lock", log_n, 0);
      dll_lock = 1'b1; lt = pc;
    end
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 3000 && t_end < 0; w++) @(negedge clk);
    chk(t_end >= 0, "R8", "run finished", t_end >= 0, 1);
    repeat (6) @(negedge clk);

    // R5 R7 R9: command order and targets
    seq_ok = (log_n == e_n);
    for (int i = 0; i < e_n && seq_ok; i++)
      if (log_c[i] != e_c[i] || log_s[i] != e_s[i]) seq_ok = 0;
    chk(seq_ok, "R7", $sformatf("sequence cc=%0d k=%0d/%0d", cc, k0, k1), log_n, e_n);

    if (seq_ok) begin
      // R3: first NOP time
      exp_t = imax(s + 3, SC + 1);
      if (lock_low) exp_t = imax(exp_t, lt + 2);
      chk(log_t[0] == exp_t, "R3", "first NOP cycle", log_t[0], exp_t);
      // R4 R5 R7: spacing of later commands
      bad_i = -1; bad_t = 0;
      for (int i = 1; i < e_n; i++) begin
        if (e_c[i] == 2'd2)                          exp_t = log_t[i-1] + 1;
        else if (e_c[i] == 2'd3 && e_c[i-1] == 2'd2) exp_t = log_t[i-1] + SET + 1;
        else                                         exp_t = log_t[i-1] + LAT + 1;
        if (bad_i < 0 && log_t[i] != exp_t) begin bad_i = i; bad_t = exp_t; end
      end
      chk(bad_i < 0, "R4", "command spacing", (bad_i < 0) ? 0 : log_t[bad_i], bad_t);
      chk(t_end == log_t[e_n-1] + LAT + 1, "R8", "finish cycle", t_end, log_t[e_n-1] + LAT + 1);
    end
    chk(err == err_exp, "R6", "error flag", err, err_exp);
    chk(done == !err_exp && aref_en == !err_exp, "R8", "done/refresh", {done, aref_en},
        err_exp ? 0 : 3);
    chk(v_dll == 0, "R2", "command while unlocked", v_dll, 0);
    chk(v_cke == 0, "R3", "cke vs NOP history", v_cke, 0);
    chk(v_aref == 0, "R8", "refresh differs from done", v_aref, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk({cke, dll_en, cmd_valid, aref_en, done, err} == '0, "R1", "outputs in reset",
        {cke, dll_en, cmd_valid, aref_en, done, err}, 0);
    rst_n = 1'b1;
    dll_lock = 1'b1;
    @(negedge clk);
    // R1: idle before start
    chk({cke, dll_en, cmd_valid, aref_en, done, err} == '0, "R1", "idle before start",
        {cke, dll_en, cmd_valid, aref_en, done, err}, 0);

    run_case(1, 0, 0, 0, 0, 1);
    for (int a = 1; a <= 3; a++) run_case(1, a, 0, 0, 0, 0);
    chk(cke[1] == 1'b0, "R7", "chip1 cke untouched with one chip", cke[1], 0);
    for (int a = 0; a <= 3; a++)
      for (int b = 0; b <= 3; b++) run_case(2, a, b, 0, 0, 0);
    run_case(0, 1, 2, 0, 0, 0);   // R7: count 0 means one chip
    run_case(3, 1, 2, 0, 0, 0);   // R7: count above NUM_CS clamps
    run_case(2, 1, 0, 1, 0, 0);   // R2: lock low at restart
    run_case(2, 0, 1, 0, 1, 0);   // R9: start during run
    run_case(1, 2, 0, 1, 1, 0);   // R2 R9 combined

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule